// File: doc/BRIEF.md
# Byte-Wide Nonvolatile Memory Bus Slave

This block models a byte-wide parallel nonvolatile memory as it appears on an asynchronous bus, rebuilt as clocked synchronous logic. A host drives three active-low strobes (chip select, output enable, write strobe), a 13-bit address and an 8-bit data bus. The block resamples all of them into the system clock through a two-stage synchroniser. It answers reads on a data output with a separate drive-enable for an external tri-state buffer. It also runs self-timed byte writes into an internal 8192 x 8 register array.

A write may be paced by either the write strobe or the chip select. The address is taken when the later of the two goes low, and the data when the earlier of the two returns high. The addressed byte is then erased to all ones, and a busy output stays high for a programmable number of clock cycles. The new byte is stored only when that interval ends. While busy is high, the block refuses further writes and every read returns all ones.

Top module: `nvbyte_slave`

## Requirements
- R1: Two clock edges after the inputs settle, `dout_en` is 1 when `ce_n`=0, `oe_n`=0 and `we_n`=1, and `dout` then shows the stored byte at `addr` (when not busy).
- R2: `dout_en` is 0 whenever `ce_n`=1 or `oe_n`=1. It is also 0 when `we_n`=0, even if `ce_n`=0 and `oe_n`=0, and no write begins in that case.
- R3: A write begins only when `ce_n` and `we_n` are both low and `oe_n` is high. The address stored is the one present when the later of `ce_n` or `we_n` falls, so later address changes have no effect.
- R4: The data stored is the `din` present when the earlier of `we_n` or `ce_n` rises, so later data changes have no effect.
- R5: After the write starts, `busy` is 1 for exactly WRITE_CYCLES clock cycles. It then returns to 0 and the new byte reads back.
- R6: While `busy` is 1, an enabled read returns 8'hFF, and any write cycle presented on the bus is ignored.
- R7: At the start of the interval the target byte is set to 8'hFF. If the interval is cut short by reset, the byte reads 8'hFF afterwards.
- R8: Reset sets `busy` to 0 and discards any captured address or data. Bytes not being written keep their values.
- R9: If `oe_n` goes low while `ce_n` and `we_n` are both still low after a write setup, the write is cancelled: `busy` stays 0 and the byte is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| we_n | input | 1 | Write strobe, active low, asynchronous |
| addr | input | 13 | Byte address |
| din | input | 8 | Write data from the bus |
| dout | output | 8 | Read data toward the bus |
| dout_en | output | 1 | Drive enable for the external tri-state buffer |
| busy | output | 1 | Self-timed write in progress |

## Verification
Two of the block's functions can fall in the same cycle: a bus read or a fresh write strobe can arrive while the self-timed write is still counting. The bench provokes this by presenting a read, and then a complete write cycle to a second location, within the busy window. It judges the result by the all-ones read data and by reading the second location back unchanged once busy drops. A reset issued partway through the interval is also checked: the target byte must read all ones afterwards, and a neighbouring byte must keep its value.

// File: rtl/nvb_pkg.sv
package nvb_pkg;
    localparam int NVB_AW    = 13;
    localparam int NVB_DW    = 8;
    localparam int NVB_DEPTH = 1 << NVB_AW;
    localparam logic [NVB_DW-1:0] NVB_ERASED = {NVB_DW{1'b1}};

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_PROG  = 2'd2
    } nvb_state_e;

    typedef struct packed {
        logic              ce_n;
        logic              oe_n;
        logic              we_n;
        logic [NVB_AW-1:0] addr;
        logic [NVB_DW-1:0] data;
    } nvb_bus_s;

    typedef struct packed {
        logic [NVB_AW-1:0] addr;
        logic [NVB_DW-1:0] data;
    } nvb_req_s;

    localparam int NVB_BUS_W = $bits(nvb_bus_s);
    localparam logic [NVB_BUS_W-1:0] NVB_BUS_IDLE = {3'b111, {(NVB_AW+NVB_DW){1'b0}}};

    function automatic logic strobes_low(input nvb_bus_s b);
        return !b.ce_n && !b.we_n;
    endfunction

    function automatic logic read_select(input nvb_bus_s b);
        return !b.ce_n && !b.oe_n && b.we_n;
    endfunction
endpackage

// File: rtl/nvb_sync.sv
module nvb_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[g] <= RST_VAL;
            else     stg[g] <= (g == 0) ? d : stg[(g == 0) ? 0 : g-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/nvb_timer.sv
module nvb_timer #(
    parameter int CYCLES = 625000
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic en,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || start) cnt <= '0;
        else if (en)      cnt <= cnt + 1'b1;
    end

    assign done = en && (cnt == LAST);

    a_r5_count_bounded: assert property (@(posedge clk) disable iff (rst)
        en |-> cnt <= LAST);
endmodule

// File: rtl/nvb_ctrl.sv
module nvb_ctrl
    import nvb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  nvb_bus_s bus,
    input  logic     done,
    output logic     start,
    output logic     busy,
    output nvb_req_s req
);
    nvb_state_e state, nxt;
    logic act, act_q;

    assign act = strobes_low(bus);

    always_comb begin
        nxt   = state;
        start = 1'b0;
        case (state)
            ST_IDLE:  if (act && !act_q && bus.oe_n) nxt = ST_SETUP;
            ST_SETUP: begin
                if (!bus.oe_n) nxt = ST_IDLE;
                else if (!act) begin
                    nxt   = ST_PROG;
                    start = 1'b1;
                end
            end
            ST_PROG:  if (done) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            act_q <= 1'b0;
            req   <= '0;
        end else begin
            state <= nxt;
            act_q <= act;
            if (state == ST_IDLE && nxt == ST_SETUP) req.addr <= bus.addr;
            if (start) req.data <= bus.data;
        end
    end

    assign busy = (state == ST_PROG);

    a_r9_cancel_on_oe: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SETUP && !bus.oe_n) |=> state == ST_IDLE);
    a_r6_no_setup_from_busy: assert property (@(posedge clk) disable iff (rst)
        busy |=> state != ST_SETUP);
    a_r5_done_ends_write: assert property (@(posedge clk) disable iff (rst)
        (busy && done) |=> !busy);
    a_r3_addr_frozen: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE && $past(state) != ST_IDLE) |-> $stable(req.addr));
    a_r4_data_frozen: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(req.data));
    a_r8_reset_idle: assert property (@(posedge clk)
        rst |=> state == ST_IDLE);
endmodule

// File: rtl/nvbyte_slave.sv
module nvbyte_slave
    import nvb_pkg::*;
#(
    parameter int WRITE_CYCLES = 625000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [NVB_AW-1:0] addr,
    input  logic [NVB_DW-1:0] din,
    output logic [NVB_DW-1:0] dout,
    output logic              dout_en,
    output logic              busy
);
    nvb_bus_s bus_raw, bus;
    logic [NVB_BUS_W-1:0] bus_q;
    logic start, done;
    nvb_req_s req;
    logic [NVB_DW-1:0] mem [NVB_DEPTH];

    assign bus_raw = '{ce_n: ce_n, oe_n: oe_n, we_n: we_n, addr: addr, data: din};

    nvb_sync #(.W(NVB_BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(NVB_BUS_IDLE)) u_sync (
        .clk(clk), .rst(rst), .d(bus_raw), .q(bus_q)
    );
    assign bus = nvb_bus_s'(bus_q);

    nvb_ctrl u_ctrl (
        .clk(clk), .rst(rst), .bus(bus), .done(done),
        .start(start), .busy(busy), .req(req)
    );

    nvb_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .start(start), .en(busy), .done(done)
    );

    always_ff @(posedge clk) begin
        if (start)     mem[req.addr] <= NVB_ERASED;
        else if (done) mem[req.addr] <= req.data;
    end

    assign dout_en = read_select(bus);
    assign dout    = busy ? NVB_ERASED : mem[bus.addr];

    a_r6_busy_reads_ones: assert property (@(posedge clk) disable iff (rst)
        (busy && dout_en) |-> dout == NVB_ERASED);
    a_r2_quiet_when_deselected: assert property (@(posedge clk) disable iff (rst)
        (bus.ce_n || bus.oe_n) |-> !dout_en);
endmodule

// File: tb/nvbyte_slave_test.sv
module nvbyte_slave_test;
    localparam int NCYC = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [12:0] addr = '0;
    logic [7:0]  din  = '0;
    logic [7:0]  dout;
    logic        dout_en, busy;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    always #4 clk = ~clk;

    nvbyte_slave #(.WRITE_CYCLES(NCYC)) uut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en), .busy(busy)
    );

    typedef struct {
        string      tag;
        logic [7:0] exp_dout;
        logic       exp_en;
        logic       exp_busy;
        bit         use_dout;
    } item_t;

    item_t q[$];

    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                checks++;
                if (dout_en !== it.exp_en || busy !== it.exp_busy ||
                    (it.use_dout && dout !== it.exp_dout)) begin
                    fails++;
                    $display("FAIL %s: dout=%h en=%b busy=%b expected dout=%h en=%b busy=%b",
                             it.tag, dout, dout_en, busy, it.exp_dout, it.exp_en, it.exp_busy);
                end
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input string tag, input logic en, input logic b,
                              input bit use_d, input logic [7:0] d);
        item_t it;
        it.tag = tag; it.exp_en = en; it.exp_busy = b;
        it.use_dout = use_d; it.exp_dout = d;
        q.push_back(it);
        step(1);
    endtask

    task automatic idle_bus();
        ce_n = 1; oe_n = 1; we_n = 1;
    endtask

    task automatic write_we(input logic [12:0] a, input logic [7:0] d);
        ce_n = 0; oe_n = 1; we_n = 1; addr = a; din = d;
        step(1); we_n = 0;
        step(3); we_n = 1;
        step(3); ce_n = 1;
        step(3);
    endtask

    task automatic write_ce(input logic [12:0] a, input logic [7:0] d);
        we_n = 0; oe_n = 1; ce_n = 1; addr = a; din = d;
        step(1); ce_n = 0;
        step(3); ce_n = 1;
        step(3); we_n = 1;
        step(3);
    endtask

    task automatic check_read(input string tag, input logic [12:0] a, input logic [7:0] d);
        ce_n = 0; oe_n = 0; we_n = 1; addr = a;
        step(3);
        expect_out(tag, 1'b1, 1'b0, 1'b1, d);
        idle_bus();
        step(3);
    endtask

    initial begin
        step(3);
        expect_out("R8 reset state", 1'b0, 1'b0, 1'b0, 8'h00);
        rst = 0;
        step(2);

        write_we(13'h0010, 8'hA5);
        expect_out("R5 busy after write strobe", 1'b0, 1'b1, 1'b0, 8'h00);
        ce_n = 0; oe_n = 0; we_n = 1; addr = 13'h0010;
        step(3);
        expect_out("R6 read during busy gives ones", 1'b1, 1'b1, 1'b1, 8'hFF);
        idle_bus();
        step(NCYC);
        expect_out("R5 busy cleared after interval", 1'b0, 1'b0, 1'b0, 8'h00);
        check_read("R1 read back strobe-paced write", 13'h0010, 8'hA5);

        write_ce(13'h1FFF, 8'h3C);
        step(NCYC);
        check_read("R3 select-paced write at top address", 13'h1FFF, 8'h3C);

        ce_n = 0; oe_n = 1; we_n = 1; addr = 13'h0100; din = 8'h00;
        step(2); addr = 13'h0200;
        step(2); we_n = 0;
        step(2); addr = 13'h0300; din = 8'h5A;
        step(2); we_n = 1;
        step(2); din = 8'hC3;
        step(2); ce_n = 1;
        step(3 + NCYC);
        check_read("R3 address taken at later falling strobe", 13'h0200, 8'h5A);
        check_read("R4 data taken at earlier rising strobe", 13'h0200, 8'h5A);

        write_we(13'h0300, 8'h77);
        step(NCYC);
        write_we(13'h0400, 8'h33);
        step(NCYC);
        write_we(13'h0300, 8'h44);
        write_we(13'h0400, 8'h99);
        step(NCYC);
        check_read("R6 write during busy ignored", 13'h0400, 8'h33);
        check_read("R5 first write committed", 13'h0300, 8'h44);

        ce_n = 0; we_n = 0; oe_n = 1; addr = 13'h0010; din = 8'h22;
        step(3); oe_n = 0;
        step(3); oe_n = 1; we_n = 1; ce_n = 1;
        step(3);
        expect_out("R9 cancelled write leaves busy low", 1'b0, 1'b0, 1'b0, 8'h00);
        check_read("R9 cancelled write leaves byte", 13'h0010, 8'hA5);

        ce_n = 1; oe_n = 0; we_n = 1; addr = 13'h0010;
        step(3);
        expect_out("R2 no drive when select high", 1'b0, 1'b0, 1'b0, 8'h00);
        ce_n = 0; oe_n = 1;
        step(3);
        expect_out("R2 no drive when output enable high", 1'b0, 1'b0, 1'b0, 8'h00);
        ce_n = 0; oe_n = 0; we_n = 0; din = 8'h01;
        step(3);
        expect_out("R2 no drive with write strobe low", 1'b0, 1'b0, 1'b0, 8'h00);
        idle_bus();
        step(4);
        expect_out("R2 no write started with output enable low", 1'b0, 1'b0, 1'b0, 8'h00);
        check_read("R2 byte kept", 13'h0010, 8'hA5);

        write_we(13'h0700, 8'h55);
        step(4);
        rst = 1;
        step(2);
        rst = 0;
        step(3);
        expect_out("R8 reset clears busy", 1'b0, 1'b0, 1'b0, 8'h00);
        check_read("R7 interrupted byte left erased", 13'h0700, 8'hFF);
        check_read("R8 other bytes kept over reset", 13'h0200, 8'h5A);

        step(2);
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule